// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

The block gathers a parameterised number of external interrupt request lines and presents them to a parameterised number of hart contexts. A context is one privilege mode of one hardware thread, so a core may own more than one context, for example a machine-mode context and a supervisor-mode context. Each context has its own interrupt output line. The line rises when at least one source is pending, enabled for that context, and has a priority above the context's threshold.

Each source passes through a gateway. The trigger type is fixed per source at build time: either rising-edge or level. The gateway turns the request into one pending bit and withholds further requests while the source is being serviced. Software running in a context claims the best eligible source by reading that context's claim word. It reports completion by writing the same source ID back to the same word. Handling is the same for edge and level sources.

All state is reached through a simple register port. Each access is a single-cycle read or write strobe with a byte address. Read data is registered. Source ID 0 is reserved and means "no interrupt". Source n is wired to `src_irq[n-1]`.

Top module: `irq_router`

## Requirements
- R1: After reset every priority, enable word, threshold and pending bit is 0, every `ctx_irq` bit is low, and a claim read returns 0.
- R2: The priority of source n is held in the word at byte address 4*n, for n from 1 to NUM_SRC. Only the low PRIO_W bits are stored and the upper bits read as 0. Address 0 holds no register and reads 0.
- R3: The word at address 0x1000 is read-only. Bit n shows the pending state of source n, and bit 0 reads 0.
- R4: Context c has an enable word at 0x2000 + 0x80*c, where bit n enables source n. A source not enabled for c never raises `ctx_irq[c]` and is never returned by c's claim.
- R5: Context c has a threshold word at 0x200000 + 0x1000*c. `ctx_irq[c]` is high exactly when some pending source enabled for c has a priority strictly greater than that threshold.
- R6: A read of c's claim word at 0x200004 + 0x1000*c returns the ID of the pending source enabled for c that has the highest non-zero priority. Ties go to the lowest ID, the threshold is not applied, and the read returns 0 when no source qualifies.
- R7: A claim read that returns a non-zero ID clears that source's pending bit from the next cycle on.
- R8: A source whose priority is 0 never raises any `ctx_irq` and is never returned by a claim, even while its pending bit is set.
- R9: A level source (SRC_EDGE bit n-1 = 0) becomes pending while its input is high and it is not in service. After it is claimed, it is not made pending again until a completion, after which the input is sampled again.
- R10: An edge source (SRC_EDGE bit n-1 = 1) becomes pending on a rising input. Several edges seen before a claim yield one pending request. One edge seen while the source is in service is held and becomes pending when the completion arrives.
- R11: Writing ID n to c's claim word completes source n. The write is ignored if n is 0, if n is above NUM_SRC, or if source n is not enabled for c.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_SRC | Interrupt request lines; bit n-1 belongs to source ID n |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe; a claim read has a side effect |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ctx_irq | output | NUM_CTX | Interrupt output line of each context |

## Verification
The bench first probes equal priorities and a priority equal to the threshold. A design that picks the highest ID on a tie, or compares with greater-or-equal, claims the wrong source or raises a line too early. It then sends edges to a source that is already in service and sends repeated edges to a pending source. A gateway that drops the held edge never re-pends, and one that counts edges returns the same ID twice. Completions from a context where the source is not enabled, and completions with an out-of-range ID, must leave the held request untouched; a design that accepts them re-pends the source early. A zero-priority source that is pending, and the last context index, are also covered, so that errors in the eligibility test or in the address decode show up at the ports.

// File: rtl/irq_router_pkg.sv
// Package: shared register-window constants and the decoded region type
// for the interrupt router. Assumes byte addresses and 32-bit words.
package irq_router_pkg;

    // Fixed layout of the register window
    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam int          EN_SHIFT   = 7;     // 0x80 bytes per context
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam int          CTX_SHIFT  = 12;    // 0x1000 bytes per context
    localparam logic [31:0] CLAIM_OFS  = 32'h0000_0004;

    // Which register an address selects
    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } reg_region_e;

endpackage

// File: rtl/irq_gateway.sv
// Module: per-source gateway. Converts an edge or level request into a
// single pending bit and blocks new requests while the source is in
// service. Assumes at most one claim pulse per cycle and that claim is
// only raised while the pending bit is set.
module irq_gateway #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic claim,
    input  logic done,
    output logic pending,
    output logic in_svc
);

    logic prev_q;
    logic held_q;
    logic req;

    // Request seen this cycle: rising edge or high level, per build choice
    always_comb begin
        if (EDGE) req = req_in & ~prev_q;
        else      req = req_in;
    end

    // Gateway state: pending, in-service and one held edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            held_q  <= 1'b0;
            pending <= 1'b0;
            in_svc  <= 1'b0;
        end else begin
            prev_q <= req_in;
            if (claim) begin
                pending <= 1'b0;
                in_svc  <= 1'b1;
                held_q  <= EDGE & req;
            end else if (done && in_svc) begin
                in_svc  <= 1'b0;
                pending <= held_q;
                held_q  <= 1'b0;
            end else if (!in_svc && req) begin
                pending <= 1'b1;
            end else if (in_svc && req && EDGE) begin
                held_q  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_ctx_arbiter.sv
// Module: per-context selector. Finds the pending, enabled source with the
// highest non-zero priority (lowest ID wins ties) and drives the context's
// line when that priority exceeds the threshold. Purely combinational.
module irq_ctx_arbiter #(
    parameter int NUM_SRC = 10,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 4
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             en,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thresh,
    output logic [ID_W-1:0]                best_id,
    output logic                           irq
);

    logic [PRIO_W-1:0] best_prio;

    // Linear scan: strict compare keeps the lowest ID on ties and skips 0
    always_comb begin
        best_prio = '0;
        best_id   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > best_prio)) begin
                best_prio = prio[i];
                best_id   = ID_W'(i + 1);
            end
        end
    end

    // Line raised only above the context threshold
    always_comb irq = (best_prio > thresh);

endmodule

// File: rtl/irq_reg_decode.sv
// Module: address decoder for the register window. Maps a byte address
// onto a region, a source ID and a context index. Unaligned or unmapped
// addresses decode to RG_NONE. Assumes ADDR_W <= 32.
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int NUM_CTX = 9,
    parameter int ADDR_W  = 26,
    parameter int ID_W    = 4,
    parameter int CTX_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_region_e       region,
    output logic [ID_W-1:0]   src_id,
    output logic [CTX_W-1:0]  ctx
);

    logic [31:0] a;
    logic [31:0] en_off;
    logic [31:0] ctx_off;

    // Offsets inside the enable and per-context areas
    always_comb begin
        a       = 32'(addr);
        en_off  = a - EN_BASE;
        ctx_off = a - CTX_BASE;
    end

    // Region select
    always_comb begin
        region = RG_NONE;
        src_id = '0;
        ctx    = '0;
        if (a[1:0] == 2'b00) begin
            if (a < PEND_BASE) begin
                if ((a >> 2) >= 32'd1 && (a >> 2) <= 32'(NUM_SRC)) begin
                    region = RG_PRIO;
                    src_id = ID_W'(a >> 2);
                end
            end else if (a == PEND_BASE) begin
                region = RG_PEND;
            end else if (a >= EN_BASE && a < CTX_BASE) begin
                if ((en_off >> EN_SHIFT) < 32'(NUM_CTX) &&
                    en_off[EN_SHIFT-1:0] == '0) begin
                    region = RG_EN;
                    ctx    = CTX_W'(en_off >> EN_SHIFT);
                end
            end else if (a >= CTX_BASE) begin
                if ((ctx_off >> CTX_SHIFT) < 32'(NUM_CTX)) begin
                    ctx = CTX_W'(ctx_off >> CTX_SHIFT);
                    if (ctx_off[CTX_SHIFT-1:0] == '0)
                        region = RG_THR;
                    else if (32'(ctx_off[CTX_SHIFT-1:0]) == CLAIM_OFS)
                        region = RG_CLAIM;
                end
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
// Module: interrupt router top. Holds priorities, per-context enables and
// thresholds, instantiates one gateway per source and one selector per
// context, and serves the register port. Assumes NUM_SRC < DATA_W so the
// pending and enable bits fit one word, and one access per cycle.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int               NUM_SRC  = 10,
    parameter int               NUM_CTX  = 9,
    parameter int               PRIO_W   = 3,
    parameter int               ADDR_W   = 26,
    parameter int               DATA_W   = 32,
    parameter logic [NUM_SRC-1:0] SRC_EDGE = 10'b11111_00000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_CTX-1:0] ctx_irq
);

    localparam int ID_W  = $clog2(NUM_SRC + 1);
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
    logic [NUM_CTX-1:0][ID_W-1:0]    best_id;
    logic [NUM_SRC-1:0]              pend_vec;
    logic [NUM_SRC-1:0]              svc_vec;
    logic [NUM_SRC-1:0]              claim_vec;
    logic [NUM_SRC-1:0]              done_vec;
    logic [DATA_W-1:0]               rd_mux;
    logic [DATA_W-1:0]               rdata_q;
    logic [ID_W-1:0]                 claim_id;
    logic                            done_ok;

    reg_region_e      dec_region;
    logic [ID_W-1:0]  dec_id;
    logic [CTX_W-1:0] dec_ctx;

    irq_reg_decode #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W),
        .ID_W    (ID_W),
        .CTX_W   (CTX_W)
    ) u_dec (
        .addr   (reg_addr),
        .region (dec_region),
        .src_id (dec_id),
        .ctx    (dec_ctx)
    );

    // One gateway per source, trigger type chosen per bit of SRC_EDGE
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gw
        irq_gateway #(.EDGE(SRC_EDGE[s])) u_gw (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_in  (src_irq[s]),
            .claim   (claim_vec[s]),
            .done    (done_vec[s]),
            .pending (pend_vec[s]),
            .in_svc  (svc_vec[s])
        );
    end

    // One selector per context
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irq_ctx_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_arb (
            .pend    (pend_vec),
            .en      (en_q[c]),
            .prio    (prio_q),
            .thresh  (thr_q[c]),
            .best_id (best_id[c]),
            .irq     (ctx_irq[c])
        );
    end

    // Claim: the selected context's winner leaves the pending set
    always_comb begin
        claim_id = best_id[dec_ctx];
        for (int i = 0; i < NUM_SRC; i++)
            claim_vec[i] = reg_rd && (dec_region == RG_CLAIM) &&
                           (claim_id == ID_W'(i + 1));
    end

    // Completion: ID in range and enabled for the writing context
    always_comb begin
        done_ok = reg_wr && (dec_region == RG_CLAIM) &&
                  (reg_wdata >= DATA_W'(1)) &&
                  (reg_wdata <= DATA_W'(NUM_SRC));
        for (int i = 0; i < NUM_SRC; i++)
            done_vec[i] = done_ok && en_q[dec_ctx][i] &&
                          (reg_wdata == DATA_W'(i + 1));
    end

    // Configuration registers: priority, enable and threshold writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (reg_wr) begin
            case (dec_region)
                RG_PRIO: prio_q[dec_id - ID_W'(1)] <= reg_wdata[PRIO_W-1:0];
                RG_EN:   en_q[dec_ctx] <= reg_wdata[NUM_SRC:1];
                RG_THR:  thr_q[dec_ctx] <= reg_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer over the decoded region
    always_comb begin
        case (dec_region)
            RG_PRIO:  rd_mux = DATA_W'(prio_q[dec_id - ID_W'(1)]);
            RG_PEND:  rd_mux = DATA_W'({pend_vec, 1'b0});
            RG_EN:    rd_mux = DATA_W'({en_q[dec_ctx], 1'b0});
            RG_THR:   rd_mux = DATA_W'(thr_q[dec_ctx]);
            RG_CLAIM: rd_mux = DATA_W'(claim_id);
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/irq_router_chk.sv
// Module: assertion checker for irq_router, attached through bind.
// Observes gateway state, claim pulses, enables and priorities.
module irq_router_chk #(
    parameter int NUM_SRC = 10,
    parameter int NUM_CTX = 9,
    parameter int PRIO_W  = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CTX-1:0]              ctx_irq,
    input logic [NUM_SRC-1:0]              pend_vec,
    input logic [NUM_SRC-1:0]              svc_vec,
    input logic [NUM_SRC-1:0]              claim_vec,
    input logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (ctx_irq == '0));

    // R7
    one_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
        // R4
        line_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_irq[c] |-> ((pend_vec & en_q[c]) != '0));
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
        // R7
        claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            claim_vec[s] |=> !pend_vec[s]);
        // R8
        zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (prio_q[s] == '0) |-> !claim_vec[s]);
        // R9
        svc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            svc_vec[s] |-> !pend_vec[s]);
        // R6
        claim_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            claim_vec[s] |-> pend_vec[s]);
    end

endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx_irq   (ctx_irq),
    .pend_vec  (pend_vec),
    .svc_vec   (svc_vec),
    .claim_vec (claim_vec),
    .en_q      (en_q),
    .prio_q    (prio_q)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them one cycle after each read strobe; line checks are made directly.
module tb_irq_router;

    localparam int NS = 10;
    localparam int NC = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [25:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] ctx_irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic rd_d = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    irq_router dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctx_irq   (ctx_irq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] a_prio(int id); return 32'(4 * id); endfunction
    function automatic logic [31:0] a_pend(); return 32'h1000; endfunction
    function automatic logic [31:0] a_en(int c); return 32'h2000 + 32'(c * 128); endfunction
    function automatic logic [31:0] a_thr(int c); return 32'h20_0000 + 32'(c * 4096); endfunction
    function automatic logic [31:0] a_clm(int c); return a_thr(c) + 32'd4; endfunction

    // Read strobe seen by the design at this posedge
    always @(posedge clk) rd_d <= reg_rd;

    // Monitor: data is due one cycle after the strobe (R12)
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R12: unexpected read data %0h, expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (reg_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: read got %0h expected %0h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 26'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, logic [31:0] e, string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_rd = 1'b1; reg_addr = 26'(a);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_line(int c, logic e, string t);
        compared++;
        if (ctx_irq[c] !== e) begin
            mismatched++;
            $display("FAIL %s: ctx_irq[%0d] got %b expected %b", t, c, ctx_irq[c], e);
        end
    endtask

    task automatic pulse(int id);
        @(negedge clk); src_irq[id-1] = 1'b1;
        @(negedge clk); src_irq[id-1] = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_line(0, 1'b0, "R1");
        compared++;
        if (ctx_irq !== '0) begin
            mismatched++;
            $display("FAIL R1: ctx_irq got %0h expected 0", ctx_irq);
        end
        rd(a_prio(1), 0, "R1 prio");
        rd(a_en(0), 0, "R1 enable");
        rd(a_thr(0), 0, "R1 threshold");
        rd(a_clm(0), 0, "R1 claim");

        // R2 priority storage and masking
        wr(a_prio(4), 32'hFD);
        rd(a_prio(4), 5, "R2 masked prio");
        wr(a_prio(0), 32'h7);
        rd(a_prio(0), 0, "R2 address 0");

        // Level sources 1..3 on ctx0, ties between 2 and 3
        wr(a_prio(1), 2);
        wr(a_prio(2), 5);
        wr(a_prio(3), 5);
        wr(a_en(0), 32'h0E);
        rd(a_en(0), 32'h0E, "R4 enable readback");
        @(negedge clk); src_irq[2:0] = 3'b111;
        idle(2);
        chk_line(0, 1'b1, "R5 line up");
        chk_line(1, 1'b0, "R4 not enabled");
        rd(a_pend(), 32'h0E, "R3 pending word");
        rd(a_clm(0), 2, "R6 tie lowest ID");
        rd(a_clm(0), 3, "R6 next");
        rd(a_clm(0), 1, "R6 lower prio");
        rd(a_clm(0), 0, "R7 all claimed");
        chk_line(0, 1'b0, "R9 held in service");
        wr(a_clm(0), 2);
        idle(2);
        rd(a_clm(0), 2, "R9 resampled after completion");
        @(negedge clk); src_irq[2:0] = 3'b000;
        wr(a_clm(0), 1);
        wr(a_clm(0), 2);
        wr(a_clm(0), 3);
        idle(2);
        rd(a_pend(), 0, "R9 low input stays idle");
        wr(a_pend(), 32'hFFFF);
        rd(a_pend(), 0, "R3 read-only");

        // Threshold and edge source 6 on ctx1
        wr(a_prio(6), 4);
        wr(a_en(1), 32'h40);
        wr(a_thr(1), 4);
        rd(a_thr(1), 4, "R5 threshold readback");
        pulse(6);
        idle(2);
        chk_line(1, 1'b0, "R5 equal to threshold");
        rd(a_pend(), 32'h40, "R10 edge pends");
        wr(a_thr(1), 3);
        idle(1);
        chk_line(1, 1'b1, "R5 above threshold");
        chk_line(0, 1'b0, "R4 ctx0 not enabled");
        rd(a_clm(0), 0, "R4 claim from ctx0");
        rd(a_clm(1), 6, "R6 claim edge source");
        pulse(6);
        idle(2);
        rd(a_pend(), 0, "R10 edge held in service");
        chk_line(1, 1'b0, "R10 line low in service");
        wr(a_clm(0), 6);
        idle(2);
        rd(a_pend(), 0, "R11 completion from non-enabled ctx");
        wr(a_clm(1), 11);
        idle(2);
        rd(a_pend(), 0, "R11 out-of-range ID");
        wr(a_clm(1), 0);
        idle(2);
        rd(a_pend(), 0, "R11 ID zero");
        wr(a_clm(1), 6);
        idle(2);
        rd(a_pend(), 32'h40, "R10 held edge released");
        rd(a_clm(1), 6, "R10 claim held edge");
        wr(a_clm(1), 6);
        pulse(6);
        pulse(6);
        idle(2);
        rd(a_clm(1), 6, "R10 merged edges");
        rd(a_clm(1), 0, "R10 only one request");
        wr(a_clm(1), 6);

        // Zero priority on ctx2
        wr(a_en(2), 32'h80);
        pulse(7);
        idle(2);
        chk_line(2, 1'b0, "R8 zero priority line");
        rd(a_pend(), 32'h80, "R8 pending shown");
        rd(a_clm(2), 0, "R8 zero priority claim");
        wr(a_prio(7), 1);
        idle(1);
        chk_line(2, 1'b1, "R8 priority raised");
        rd(a_clm(2), 7, "R6 claim after priority set");
        wr(a_clm(2), 7);

        // Last context, highest ID
        wr(a_prio(10), 7);
        wr(a_en(8), 32'h400);
        pulse(10);
        idle(2);
        chk_line(8, 1'b1, "R5 last context");
        chk_line(7, 1'b0, "R4 neighbour context");
        rd(a_clm(8), 10, "R12 claim last ID");
        chk_line(8, 1'b0, "R7 line drops after claim");

        idle(3);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R12: %0d reads never returned, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule